// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block produces the internal address for a four-beat burst in a synchronous burst memory. A starting address is captured when either of two active-low load strobes qualifies it. One strobe, the controller strobe, loads on its own. The other, the processor strobe, loads only while the active-low chip enable is asserted. After a load, each clock with the active-low advance input asserted moves the burst one beat forward.

Only the two least-significant address bits follow the beat sequence. The upper bits stay exactly as they were captured. A static order input selects the beat order. Linear order adds the beat number to the starting low bits, modulo four. Interleaved order XORs the starting low bits with the beat number. The address width is a parameter, so the same block serves 18-bit and 19-bit memory organisations.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `addr_out` is all zeros.
- R2: A low `ctrl_strobe_n` at a rising edge loads `addr_in`, whatever the state of `chip_en_n`. From the next cycle `addr_out` equals the loaded address, which is beat 0.
- R3: A low `proc_strobe_n` loads `addr_in` only when `chip_en_n` is also low. With `chip_en_n` high and `ctrl_strobe_n` high, no load takes place and the address is unchanged.
- R4: Without a load, a low `advance_n` at a rising edge moves the burst forward one beat. A high `advance_n` keeps `addr_out` unchanged.
- R5: With `order_il` = 0 (linear), `addr_out[1:0]` = (start + beat) mod 4. For example, start 2 gives 2,3,0,1.
- R6: With `order_il` = 1 (interleaved), `addr_out[1:0]` = start XOR beat. For example, start 1 gives 1,0,3,2 and start 2 gives 2,3,0,1.
- R7: A load in the same cycle as a low `advance_n` takes priority over the advance. The new burst starts at beat 0.
- R8: After the fourth beat, further advances wrap back to the starting low bits. `addr_out[ADDR_W-1:2]` never changes except on a load.
- R9: `order_il` may change only in a cycle that also presents a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| addr_in | input | ADDR_W | Starting address offered for capture |
| ctrl_strobe_n | input | 1 | Active-low controller load strobe, not gated by chip enable |
| proc_strobe_n | input | 1 | Active-low processor load strobe, gated by chip enable |
| chip_en_n | input | 1 | Active-low chip enable qualifying the processor strobe |
| advance_n | input | 1 | Active-low burst advance |
| order_il | input | 1 | Beat order: 0 linear, 1 interleaved |
| addr_out | output | ADDR_W | Captured upper bits with sequenced low two bits |

## Verification
The bench looks for the places where the two orders diverge. It uses a start of 1, where linear gives 1,2,3,0 but interleaved gives 1,0,3,2. A design that applied one formula in both modes would fail there. It also uses a start of 2, where the orders agree. The bench drives a processor strobe with chip enable inactive; a design missing the chip-enable gate would capture the address. It advances a fifth time past the end of a burst. A counter wider than two bits, or one that carries into the upper bits, would show up there as a changed upper field. Finally, it presents a load and an advance together. A design that let the advance win would start the new burst at beat 1.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

    localparam int BEAT_W = 2;

    typedef logic [BEAT_W-1:0] beat_t;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_e;

    // Low address bits for beat n of a burst that began at start.
    function automatic beat_t seq_low(beat_t start, beat_t n, order_e ord);
        beat_t r;
        if (ord == ORD_INTERLEAVE) r = start ^ n;
        else                       r = beat_t'(start + n);
        return r;
    endfunction

endpackage

// File: rtl/burst_load_qual.sv
module burst_load_qual (
    input  logic ctrl_strobe_n,
    input  logic proc_strobe_n,
    input  logic chip_en_n,
    output logic load
);
    logic ctrl_req;
    logic proc_req;

    always_comb begin
        ctrl_req = ~ctrl_strobe_n;
        proc_req = ~proc_strobe_n & ~chip_en_n;
        load     = ctrl_req | proc_req;
    end
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
    import burst_addr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  logic  step,
    output beat_t beat
);
    beat_t cnt;

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (load) cnt <= '0;
        else if (step) cnt <= beat_t'(cnt + beat_t'(1));
    end

    assign beat = cnt;

    assert_step_R4: assert property (@(posedge clk) disable iff (rst)
        (!load && step) |=> (cnt == beat_t'($past(cnt) + beat_t'(1))));

    assert_load_zero_R7: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt == '0));
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_addr_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              ctrl_strobe_n,
    input  logic              proc_strobe_n,
    input  logic              chip_en_n,
    input  logic              advance_n,
    input  logic              order_il,
    output logic [ADDR_W-1:0] addr_out
);
    localparam int UP_W = ADDR_W - BEAT_W;

    typedef struct packed {
        logic [UP_W-1:0] upper;
        beat_t           start;
    } base_t;

    base_t base_q;
    logic  load;
    beat_t beat;
    beat_t low;

    burst_load_qual u_qual (
        .ctrl_strobe_n (ctrl_strobe_n),
        .proc_strobe_n (proc_strobe_n),
        .chip_en_n     (chip_en_n),
        .load          (load)
    );

    burst_beat_ctr u_ctr (
        .clk  (clk),
        .rst  (rst),
        .load (load),
        .step (~advance_n),
        .beat (beat)
    );

    always_ff @(posedge clk) begin
        if (rst)       base_q <= '0;
        else if (load) base_q <= base_t'(addr_in);
    end

    always_comb begin
        low      = seq_low(base_q.start, beat, order_e'(order_il));
        addr_out = {base_q.upper, low};
    end

    assert_load_capture_R2: assert property (@(posedge clk) disable iff (rst)
        !ctrl_strobe_n |=> (addr_out == $past(addr_in)));

    assert_proc_gated_R3: assert property (@(posedge clk) disable iff (rst)
        (ctrl_strobe_n && chip_en_n && advance_n) |=> $stable(addr_out));

    assert_upper_fixed_R8: assert property (@(posedge clk) disable iff (rst)
        (ctrl_strobe_n && (proc_strobe_n || chip_en_n))
            |=> $stable(addr_out[ADDR_W-1:BEAT_W]));

    assert_order_static_R9: assert property (@(posedge clk) disable iff (rst)
        !$stable(order_il) |-> load);
endmodule

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb;
    localparam int AW = 18;

    logic          clk = 1'b0;
    logic          rst;
    logic [AW-1:0] addr_in;
    logic          ctrl_strobe_n, proc_strobe_n, chip_en_n, advance_n, order_il;
    logic [AW-1:0] addr_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW)) u_dut (
        .clk           (clk),
        .rst           (rst),
        .addr_in       (addr_in),
        .ctrl_strobe_n (ctrl_strobe_n),
        .proc_strobe_n (proc_strobe_n),
        .chip_en_n     (chip_en_n),
        .advance_n     (advance_n),
        .order_il      (order_il),
        .addr_out      (addr_out)
    );

    task automatic check(string req, logic [AW-1:0] exp);
        checks++;
        if (addr_out !== exp) begin
            errors++;
            $display("FAIL %s: addr_out=%h expected=%h", req, addr_out, exp);
        end
    endtask

    // Drive inputs for one edge, then settle at the following negedge.
    task automatic cyc(logic [AW-1:0] a, logic c_n, logic p_n, logic ce_n, logic adv_n);
        addr_in = a; ctrl_strobe_n = c_n; proc_strobe_n = p_n;
        chip_en_n = ce_n; advance_n = adv_n;
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [AW-1:0] mk(logic [AW-1:0] a, logic [1:0] lo);
        return {a[AW-1:2], lo};
    endfunction

    task automatic t_reset;
        rst = 1'b1; order_il = 1'b0;
        cyc('0, 1, 1, 1, 1);
        cyc('0, 1, 1, 1, 1);
        check("R1", '0);
        rst = 1'b0;
        cyc(18'h3FFFF, 1, 1, 1, 1);
        check("R1", '0);
    endtask

    task automatic t_linear;
        logic [AW-1:0] a = 18'h1ABC6;
        cyc(a, 0, 1, 1, 1);
        check("R2", a);
        cyc('0, 1, 1, 1, 0); check("R5", mk(a, 2'd3));
        cyc('0, 1, 1, 1, 0); check("R5", mk(a, 2'd0));
        cyc('0, 1, 1, 1, 0); check("R5", mk(a, 2'd1));
        cyc('0, 1, 1, 1, 0); check("R8", mk(a, 2'd2));
    endtask

    task automatic t_linear_start1;
        logic [AW-1:0] a = 18'h00F05;
        cyc(a, 0, 1, 1, 0);
        check("R7", a);
        cyc('0, 1, 1, 1, 0); check("R5", mk(a, 2'd2));
        cyc('0, 1, 1, 1, 0); check("R5", mk(a, 2'd3));
        cyc('0, 1, 1, 1, 0); check("R5", mk(a, 2'd0));
    endtask

    task automatic t_proc_gate;
        logic [AW-1:0] a = 18'h2468B;
        logic [AW-1:0] held = addr_out;
        cyc(a, 1, 0, 1, 1);
        check("R3", held);
        cyc(a, 1, 0, 0, 1);
        check("R3", a);
    endtask

    task automatic t_hold;
        logic [AW-1:0] a = addr_out;
        cyc('1, 1, 1, 1, 1); check("R4", a);
        cyc('1, 1, 1, 0, 1); check("R4", a);
        cyc('0, 1, 1, 1, 0); check("R4", mk(a, 2'(a[1:0] + 2'd1)));
    endtask

    task automatic t_interleave;
        logic [AW-1:0] a = 18'h35551;
        logic [AW-1:0] b = 18'h0C0C2;
        order_il = 1'b1;
        cyc(a, 0, 1, 1, 1); check("R6", a);
        cyc('0, 1, 1, 1, 0); check("R6", mk(a, 2'd0));
        cyc('0, 1, 1, 1, 0); check("R6", mk(a, 2'd3));
        cyc('0, 1, 1, 1, 0); check("R6", mk(a, 2'd2));
        cyc('0, 1, 1, 1, 0); check("R8", mk(a, 2'd1));
        cyc(b, 1, 0, 0, 1); check("R6", b);
        cyc('0, 1, 1, 1, 0); check("R6", mk(b, 2'd3));
        cyc('0, 1, 1, 1, 0); check("R6", mk(b, 2'd0));
        cyc('0, 1, 1, 1, 0); check("R6", mk(b, 2'd1));
    endtask

    task automatic t_priority;
        logic [AW-1:0] a = 18'h3FFFF;
        cyc(a, 1, 0, 0, 0);
        check("R7", a);
        cyc('0, 1, 1, 1, 0); check("R8", mk(a, 2'd2));
        cyc('0, 1, 1, 1, 0); check("R8", mk(a, 2'd1));
        cyc('0, 1, 1, 1, 0); check("R8", mk(a, 2'd0));
        cyc('0, 1, 1, 1, 0); check("R8", mk(a, 2'd3));
    endtask

    initial begin
        rst = 1'b1; addr_in = '0; ctrl_strobe_n = 1'b1; proc_strobe_n = 1'b1;
        chip_en_n = 1'b1; advance_n = 1'b1; order_il = 1'b0;
        @(negedge clk);
        t_reset();
        t_linear();
        t_linear_start1();
        t_proc_gate();
        t_hold();
        t_interleave();
        t_priority();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: addr_out=%h expected=done", addr_out);
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule